// File: doc/BRIEF.md
# Asynchronous serial receiver with break capture

The block receives characters from an asynchronous serial line. The line is sampled on a clock-enable tick that runs at sixteen times the bit rate. A start bit is accepted only after a confirmation at its midpoint. Each data bit, the optional parity slot and the first stop bit are then sampled at their centres. Every finished character goes into a small receive queue together with three tags: line break, framing error and parity error.

The character length runs from 5 to 8 bits, and data arrives least significant bit first. Four parity modes are supported: computed even/odd, forced level, none, and multidrop. In multidrop mode the parity slot carries an address/data marker, and that marker is reported in place of an error result.

A break is a character in which every bit is low, including the parity slot and the stop bit. A break yields exactly one queue entry. After a break the receiver ignores the line until it has stayed high for half a bit time. A break that starts partway through a character first produces that character with a framing error, and is then reported on the following character time.

The consumer watches `rx_rdy_o`, reads the head entry and its tags, and pulses `rd_i` to pop it.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset `rx_rdy_o`, `data_o`, `brk_o`, `ferr_o`, `perr_o` and `ovr_o` are all 0.
- R2: A falling edge starts a character only if the line is still low 8 ticks later. A shorter low pulse produces no entry.
- R3: `char_len_i` selects the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Bits arrive LSB first. `data_o` is right-aligned and its unused upper bits are 0.
- R4: With `par_mode_i` = 00, the parity slot follows the data. The expected bit makes the total count of ones even when `par_odd_i` = 0 and odd when `par_odd_i` = 1. `perr_o` is 1 on a mismatch.
- R5: With `par_mode_i` = 01, the expected parity bit equals `par_odd_i`, and `perr_o` flags a mismatch.
- R6: With `par_mode_i` = 10, there is no parity slot and `perr_o` is 0.
- R7: With `par_mode_i` = 11, the parity slot is present and `perr_o` holds the received slot value.
- R8: The first stop bit is sampled at its centre. A low sample sets `ferr_o` for that entry.
- R9: A character whose data bits, parity slot and stop bit are all low produces exactly one entry, with data 0, `brk_o` = 1 and `ferr_o` = 1.
- R10: After a break, no entry is written until the line has been high for 8 consecutive ticks. A low period during that wait, even one long enough to pass as a start bit, is ignored.
- R11: The queue holds 8 entries, returned in arrival order. A pulse on `rd_i` pops the head. The tags and data read 0 while `rx_rdy_o` is 0.
- R12: A character that completes while the queue is full is discarded and sets the sticky `ovr_o`. The stored entries are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable at 16x bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| char_len_i | input | 2 | Character length code |
| par_mode_i | input | 2 | Parity mode code |
| par_odd_i | input | 1 | Odd select / forced parity level |
| rd_i | input | 1 | Pop head entry |
| rx_rdy_o | output | 1 | Queue not empty |
| data_o | output | 8 | Head entry data |
| brk_o | output | 1 | Head entry break tag |
| ferr_o | output | 1 | Head entry framing error tag |
| perr_o | output | 1 | Head entry parity error / address bit |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The main path is swept over all four lengths, all four parity modes and both odd/even selections. Each combination is run with data patterns that vary the parity of the ones count. Every other character carries a deliberately wrong parity slot, which separates mismatch detection from the multidrop pass-through and from the no-parity case.

Three line patterns test the framing logic:
- a stop bit that is low at its centre tells a framing error apart from a break;
- a short low glitch tests the start-bit confirmation;
- a long break followed by a start-like low pulse inside the half-bit wait shows whether entries are suppressed after a break.

Nine back-to-back characters with no reads show that arrival order is kept and that the overflowing character is dropped.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned RX_DW = 8;

  localparam logic [1:0] PM_CALC  = 2'b00;
  localparam logic [1:0] PM_FORCE = 2'b01;
  localparam logic [1:0] PM_NONE  = 2'b10;
  localparam logic [1:0] PM_MULTI = 2'b11;

  typedef struct packed {
    logic             brk;
    logic             ferr;
    logic             perr;
    logic [RX_DW-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic [1:0] char_len_i,
  input  logic [1:0] par_mode_i,
  input  logic      par_odd_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned HALF = OVS / 2;
  localparam int unsigned HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_MID = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
  localparam logic [HW-1:0] HI_END  = HW'(HALF - 1);

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic [2:0]       bit_idx_q;
  logic [RX_DW-1:0] shreg_q;
  logic             par_bit_q;
  logic [HW-1:0]    hi_cnt_q;

  logic             has_par;
  logic [2:0]       last_idx;
  logic [1:0]       align_sh;
  logic [RX_DW-1:0] data_al;
  logic             exp_par, perr_c, brk_c;

  assign rx_s     = sync_q[1];
  assign has_par  = (par_mode_i != PM_NONE);
  assign last_idx = {1'b0, char_len_i} + 3'd4;
  assign align_sh = 2'd3 - char_len_i;
  assign data_al  = shreg_q >> align_sh;
  assign exp_par  = (par_mode_i == PM_FORCE) ? par_odd_i : ((^data_al) ^ par_odd_i);
  assign brk_c    = !rx_s && (data_al == '0) && !(has_par && par_bit_q);

  always_comb begin
    unique case (par_mode_i)
      PM_MULTI: perr_c = par_bit_q;
      PM_NONE:  perr_c = 1'b0;
      default:  perr_c = par_bit_q ^ exp_par;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_idx_q <= '0;
      shreg_q   <= '0;
      par_bit_q <= 1'b0;
      hi_cnt_q  <= '0;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_s) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              // start confirmed only if still low at mid-bit
              if (rx_s) state_q <= ST_IDLE;
              else begin
                state_q   <= ST_DATA;
                cnt_q     <= '0;
                bit_idx_q <= '0;
                par_bit_q <= 1'b0;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == CNT_END) begin
              cnt_q   <= '0;
              shreg_q <= {rx_s, shreg_q[RX_DW-1:1]};
              if (bit_idx_q == last_idx) state_q <= has_par ? ST_PAR : ST_STOP;
              else bit_idx_q <= bit_idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (cnt_q == CNT_END) begin
              cnt_q     <= '0;
              par_bit_q <= rx_s;
              state_q   <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == CNT_END) begin
              cnt_q         <= '0;
              push_o        <= 1'b1;
              entry_o.brk   <= brk_c;
              entry_o.ferr  <= !rx_s;
              entry_o.perr  <= perr_c;
              entry_o.data  <= data_al;
              hi_cnt_q      <= '0;
              state_q       <= brk_c ? ST_BRKWAIT : ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_BRKWAIT: begin
            if (rx_s) begin
              if (hi_cnt_q == HI_END) state_q <= ST_IDLE;
              else hi_cnt_q <= hi_cnt_q + 1'b1;
            end else hi_cnt_q <= '0;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_push_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(tick_i));
  assert_brk_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && entry_o.brk) |-> (entry_o.data == '0 && entry_o.ferr));
  assert_brk_wait_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRKWAIT) |=> !push_o);
  assert_start_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == CNT_MID && rx_s) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import serial_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      ovr_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
      if (push_i && full) ovr_o <= 1'b1;
    end
  end

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_ovr_on_full_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(full && push_i));
  assert_pop_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rxd_i,
  input  logic [1:0]       char_len_i,
  input  logic [1:0]       par_mode_i,
  input  logic             par_odd_i,
  input  logic             rd_i,
  output logic             rx_rdy_o,
  output logic [RX_DW-1:0] data_o,
  output logic             brk_o,
  output logic             ferr_o,
  output logic             perr_o,
  output logic             ovr_o
);
  logic      push, empty;
  rx_entry_t entry, head;

  serial_rx_sampler #(.OVS(OVS)) u_sampler (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .char_len_i, .par_mode_i, .par_odd_i,
    .push_o(push), .entry_o(entry)
  );

  serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .entry_i(entry), .pop_i(rd_i),
    .head_o(head), .empty_o(empty), .ovr_o
  );

  assign rx_rdy_o = !empty;
  assign data_o   = rx_rdy_o ? head.data : '0;
  assign brk_o    = rx_rdy_o & head.brk;
  assign ferr_o   = rx_rdy_o & head.ferr;
  assign perr_o   = rx_rdy_o & head.perr;

  assert_tags_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_rdy_o) |-> !(brk_o || ferr_o || perr_o));
endmodule

// File: tb/serial_rx_brk_tb_top.sv
module serial_rx_brk_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] char_len_i = 2'b11;
  logic [1:0] par_mode_i = 2'b10;
  logic       par_odd_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       rx_rdy_o, brk_o, ferr_o, perr_o, ovr_o;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  serial_rx_brk dut_i (.*);

  always #5 clk_i = ~clk_i;

  initial forever begin
    @(negedge clk_i);
    tick_i = ~tick_i;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (2 * n) @(negedge clk_i);
  endtask

  task automatic pop();
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  // stop_lo_ticks = 0 gives a normal high stop bit
  task automatic send(logic [7:0] d, int len, bit has_par, logic pb, int stop_lo_ticks);
    rxd_i = 1'b0; ticks(16);
    for (int i = 0; i < len; i++) begin rxd_i = d[i]; ticks(16); end
    if (has_par) begin rxd_i = pb; ticks(16); end
    if (stop_lo_ticks > 0) begin rxd_i = 1'b0; ticks(stop_lo_ticks); end
    rxd_i = 1'b1; ticks(20);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ticks(3);
    rst_ni = 1'b1;
    ticks(3);
    // R1 reset state
    chk("R1 rdy", rx_rdy_o, 0);
    chk("R1 tags", {data_o, brk_o, ferr_o, perr_o}, 0);
    chk("R1 ovr", ovr_o, 0);

    // R3..R7 sweep
    for (int len = 5; len <= 8; len++)
      for (int mode = 0; mode < 4; mode++)
        for (int odd = 0; odd < 2; odd++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] d, m;
            logic flip, pb, eperr;
            string rq;
            d = 8'h5A ^ 8'(k * 8'h63 + len * 7 + mode * 3);
            m = d & 8'((1 << len) - 1);
            flip = k[0];
            case (mode)
              0: begin pb = (^m) ^ odd[0] ^ flip; eperr = flip; rq = "R4"; end
              1: begin pb = odd[0] ^ flip;        eperr = flip; rq = "R5"; end
              2: begin pb = 1'b0;                 eperr = 1'b0; rq = "R6"; end
              default: begin pb = flip;           eperr = flip; rq = "R7"; end
            endcase
            char_len_i = 2'(len - 5);
            par_mode_i = 2'(mode);
            par_odd_i  = odd[0];
            send(d, len, mode != 2, pb, 0);
            chk("R11 rdy", rx_rdy_o, 1);
            chk("R3 data", data_o, m);
            chk(rq, perr_o, eperr);
            chk("R8 no ferr", {brk_o, ferr_o}, 0);
            pop();
            chk("R11 empty", {rx_rdy_o, data_o, brk_o, ferr_o, perr_o}, 0);
          end

    char_len_i = 2'b11; par_mode_i = 2'b10; par_odd_i = 1'b0;

    // R2 short glitch
    rxd_i = 1'b0; ticks(4); rxd_i = 1'b1; ticks(30);
    chk("R2 glitch", rx_rdy_o, 0);

    // R8 low stop bit, non-zero data
    send(8'h5A, 8, 0, 0, 12);
    chk("R8 ferr", ferr_o, 1);
    chk("R8 not brk", brk_o, 0);
    chk("R8 data", data_o, 8'h5A);
    pop();
    chk("R8 single entry", rx_rdy_o, 0);

    // R9/R10 break then start-like low inside the wait
    rxd_i = 1'b0; ticks(16 * 10 + 20);
    rxd_i = 1'b1; ticks(3);
    rxd_i = 1'b0; ticks(12);
    rxd_i = 1'b1; ticks(40);
    chk("R9 rdy", rx_rdy_o, 1);
    chk("R9 tags", {data_o, brk_o, ferr_o}, {8'h00, 2'b11});
    pop();
    chk("R10 suppressed", rx_rdy_o, 0);
    send(8'h33, 8, 0, 0, 0);
    chk("R10 resumes", data_o, 8'h33);
    chk("R10 no brk", brk_o, 0);
    pop();

    // R11/R12 fill and overrun
    for (int i = 0; i < 8; i++) send(8'(8'h10 + i), 8, 0, 0, 0);
    chk("R12 no ovr at 8", ovr_o, 0);
    send(8'hEE, 8, 0, 0, 0);
    chk("R12 ovr", ovr_o, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R11 order", data_o, 8'(8'h10 + i));
      pop();
    end
    chk("R12 dropped", rx_rdy_o, 0);
    chk("R12 sticky", ovr_o, 1);

    finish_run();
  end
endmodule